// File: doc/BRIEF.md
# Triggered Ramp and Triangle Pattern Generator

This block produces a signed sample stream shaped as a rising ramp, a falling ramp or a triangle, one sample per clock of the converter clock. Generation is armed by an active-low trigger. When the trigger is seen low, the block waits a programmable start delay and then begins sweeping. The delay is never shorter than a fixed minimum. While the block is not generating, the output rests at code 0, which is the midscale of the converter.

Three counters set the timing of the ramp. A prescaler divides the clock into a time unit of 1 to 16 clocks. Each ramp code is held for a programmable number of those units. A separate period counter, also counted in those units, restarts the ramp from its first code at the end of every repetition, whatever point the sweep has reached. Raising the trigger at any time stops generation and returns the output to midscale on the next clock edge.

Top module: `saw_pattern_gen`

## Requirements
- R1: After reset, and at any time `running` is 0, `sample` is 0 and `running` is 0.
- R2: `running` rises D clock edges after the first edge that samples `trig_n` low, where D is the value of `start_delay` when that value is 14 or more. Outputs sampled after edge number D still show idle. Outputs sampled after edge number D+1 show the first code.
- R3: A `start_delay` below 14, including 0, gives a delay of exactly 14 edges.
- R4: While `trig_n` is high at a clock edge, the block is idle after that edge. This also applies during the start delay, so a trigger raised during the delay cancels the start.
- R5: With `wave_sel` = 2'b00 (rising ramp), the first code is -8192. Each step adds 1, up to 8191, and the ramp then wraps to -8192. A ramp has 16384 steps.
- R6: With `wave_sel` = 2'b01 (falling ramp), the first code is 8191. Each step subtracts 1, down to -8192, and the ramp then wraps to 8191.
- R7: With `wave_sel` = 2'b10 or 2'b11 (triangle), step s of 0..32767 gives code s-8192 for s < 16384 and 8191-(s-16384) otherwise. The triangle then repeats.
- R8: A code is held for `step_hold` × (`timebase`+1) clocks. A `step_hold` of 0 acts as 1.
- R9: The time unit is `timebase`+1 clocks, from 1 to 16.
- R10: The ramp restarts at its first code every (`timebase`+1) × `period` clocks, counted from the start of generation and independent of the ramp length. A `period` of 0 acts as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trig_n | input | 1 | Active-low trigger; low arms and runs, high stops |
| wave_sel | input | 2 | 00 rising ramp, 01 falling ramp, 1x triangle |
| step_hold | input | 6 | Time units each code is held (0 acts as 1) |
| timebase | input | 4 | Time unit length minus one, in clocks |
| period | input | 16 | Repetition length in time units (0 acts as 1) |
| start_delay | input | 16 | Clocks from trigger detection to start (minimum 14) |
| sample | output | 14 | Signed two's complement output code |
| running | output | 1 | High while samples are being generated |

## Verification
A rising ramp with unit hold is run through more than 16384 samples, which shows both the one-code-per-clock slope and the wrap from 8191 to -8192. A falling ramp with a zero hold shows the reversed direction and that a hold of 0 acts as 1. A full triangle shows the repeated peak and the turn at step 16384. A run with a multi-clock time unit, a hold of 3 and a short period separates the step time from the period restart. A period of 0 pins the output to the first code. Trigger cases cover a delay below the minimum, a long delay, release during a run and release during the delay, and each one is checked edge by edge against the idle output.

// File: rtl/saw_pattern_gen.sv
module saw_pattern_gen #(
  parameter int STEP_BITS = 14,
  parameter int HOLD_W    = 6,
  parameter int TB_W      = 4,
  parameter int PER_W     = 16,
  parameter int DLY_W     = 16,
  parameter int MIN_DELAY = 14
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        trig_n,
  input  logic [1:0]                  wave_sel,
  input  logic [HOLD_W-1:0]           step_hold,
  input  logic [TB_W-1:0]             timebase,
  input  logic [PER_W-1:0]            period,
  input  logic [DLY_W-1:0]            start_delay,
  output logic signed [STEP_BITS-1:0] sample,
  output logic                        running
);
  localparam int SEQ_BITS = STEP_BITS + 1;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_RUN} state_t;

  state_t              state;
  logic                trig_q;
  logic [DLY_W-1:0]    dly_cnt;
  logic [TB_W-1:0]     tb_cnt;
  logic [HOLD_W-1:0]   hold_cnt;
  logic [PER_W-1:0]    per_cnt;
  logic [SEQ_BITS-1:0] step;

  wire trig_fall = trig_q & ~trig_n;
  wire is_tri    = wave_sel[1];

  wire [DLY_W-1:0]  dly_eff   = (start_delay < DLY_W'(MIN_DELAY)) ? DLY_W'(MIN_DELAY) : start_delay;
  wire [HOLD_W-1:0] hold_eff  = (step_hold == '0) ? HOLD_W'(1) : step_hold;
  wire [PER_W-1:0]  per_eff   = (period == '0) ? PER_W'(1) : period;
  wire [HOLD_W-1:0] hold_last = hold_eff - HOLD_W'(1);
  wire [PER_W-1:0]  per_last  = per_eff - PER_W'(1);

  wire tb_end   = (tb_cnt == timebase);
  wire hold_end = (hold_cnt == hold_last);
  wire per_end  = (per_cnt == per_last);

  wire [STEP_BITS-1:0] low_next  = step[STEP_BITS-1:0] + STEP_BITS'(1);
  wire [SEQ_BITS-1:0]  step_next = is_tri ? step + SEQ_BITS'(1) : {1'b0, low_next};

  wire [STEP_BITS-1:0] up_code   = {~step[STEP_BITS-1], step[STEP_BITS-2:0]};
  wire [STEP_BITS-1:0] down_code = ~up_code;
  wire                 go_down   = is_tri ? step[STEP_BITS] : wave_sel[0];
  wire [STEP_BITS-1:0] code      = go_down ? down_code : up_code;

  assign running = (state == S_RUN);
  assign sample  = running ? $signed(code) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      trig_q   <= 1'b1;
      dly_cnt  <= '0;
      tb_cnt   <= '0;
      hold_cnt <= '0;
      per_cnt  <= '0;
      step     <= '0;
    end else begin
      trig_q <= trig_n;
      case (state)
        S_IDLE: begin
          if (trig_fall) begin
            state   <= S_WAIT;
            dly_cnt <= dly_eff - DLY_W'(1);
          end
        end
        S_WAIT: begin
          if (trig_n) begin
            state <= S_IDLE;
          end else if (dly_cnt == '0) begin
            state    <= S_RUN;
            tb_cnt   <= '0;
            hold_cnt <= '0;
            per_cnt  <= '0;
            step     <= '0;
          end else begin
            dly_cnt <= dly_cnt - DLY_W'(1);
          end
        end
        S_RUN: begin
          if (trig_n) begin
            state <= S_IDLE;
          end else if (!tb_end) begin
            tb_cnt <= tb_cnt + TB_W'(1);
          end else begin
            tb_cnt <= '0;
            if (per_end) begin
              per_cnt  <= '0;
              hold_cnt <= '0;
              step     <= '0;
            end else begin
              per_cnt <= per_cnt + PER_W'(1);
              if (hold_end) begin
                hold_cnt <= '0;
                step     <= step_next;
              end else begin
                hold_cnt <= hold_cnt + HOLD_W'(1);
              end
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/saw_pattern_gen_chk.sv
module saw_pattern_gen_chk #(
  parameter int STEP_BITS = 14
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        trig_n,
  input logic [1:0]                  wave_sel,
  input logic signed [STEP_BITS-1:0] sample,
  input logic                        running
);
  localparam logic [STEP_BITS-1:0] MIN_CODE = {1'b1, {(STEP_BITS-1){1'b0}}};
  localparam logic [STEP_BITS-1:0] MAX_CODE = {1'b0, {(STEP_BITS-1){1'b1}}};

  AST_IDLE_MIDSCALE: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> sample == '0); // R1

  AST_TRIG_HIGH_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    trig_n |=> !running); // R4

  AST_START_NEEDS_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> !trig_n && !$past(trig_n)); // R2

  AST_START_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> !$past(trig_n, 2)); // R3

  AST_UP_SLOPE: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running) && wave_sel == 2'b00 && $past(wave_sel) == 2'b00
     && sample != $past(sample))
    |-> (sample == $past(sample) + STEP_BITS'(1)) || (sample == MIN_CODE)); // R5

  AST_DOWN_SLOPE: assert property (@(posedge clk) disable iff (!rst_n)
    (running && $past(running) && wave_sel == 2'b01 && $past(wave_sel) == 2'b01
     && sample != $past(sample))
    |-> (sample == $past(sample) - STEP_BITS'(1)) || (sample == MAX_CODE)); // R6

  AST_FIRST_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(running) && wave_sel == 2'b01) |-> sample == MAX_CODE); // R6
endmodule

bind saw_pattern_gen saw_pattern_gen_chk #(.STEP_BITS(STEP_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .trig_n(trig_n), .wave_sel(wave_sel),
  .sample(sample), .running(running)
);

// File: tb/saw_pattern_gen_test.sv
module saw_pattern_gen_test;
  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               trig_n = 1'b1;
  logic [1:0]         wave_sel = '0;
  logic [5:0]         step_hold = '0;
  logic [3:0]         timebase = '0;
  logic [15:0]        period = '0;
  logic [15:0]        start_delay = '0;
  logic signed [13:0] sample;
  logic               running;

  typedef struct {
    logic               run;
    logic signed [13:0] smp;
    string              tag;
  } item_t;

  item_t q[$];
  int    tests = 0;
  int    fails = 0;
  bit    done  = 0;

  always #5 clk = ~clk;

  saw_pattern_gen uut (
    .clk(clk), .rst_n(rst_n), .trig_n(trig_n), .wave_sel(wave_sel),
    .step_hold(step_hold), .timebase(timebase), .period(period),
    .start_delay(start_delay), .sample(sample), .running(running)
  );

  function automatic int exp_code(input logic [1:0] sel, input int s);
    if (sel == 2'b00) return (s % 16384) - 8192;
    if (sel == 2'b01) return 8191 - (s % 16384);
    s = s % 32768;
    return (s < 16384) ? s - 8192 : 8191 - (s - 16384);
  endfunction

  task automatic push(input logic r, input int v, input string tag);
    item_t it;
    it.run = r;
    it.smp = 14'(v);
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic drain();
    while (q.size() != 0) @(negedge clk);
  endtask

  task automatic run_case(input logic [1:0] sel, input int hold, input int tb,
                          input int per, input int dly, input int n, input string tag);
    int l, h, p, d;
    l = tb + 1;
    h = (hold == 0) ? 1 : hold;
    p = (per == 0) ? 1 : per;
    d = (dly < 14) ? 14 : dly;
    @(negedge clk);
    wave_sel = sel; step_hold = 6'(hold); timebase = 4'(tb);
    period = 16'(per); start_delay = 16'(dly);
    repeat (3) @(negedge clk);
    trig_n = 1'b0;
    for (int j = 0; j < d; j++) push(1'b0, 0, "R2/R3 delay");
    for (int c = 0; c < n; c++) begin
      int cp;
      cp = c % (l * p);
      push(1'b1, exp_code(sel, cp / (l * h)), tag);
    end
    drain();
    @(negedge clk);
    trig_n = 1'b1;
    for (int j = 0; j < 4; j++) push(1'b0, 0, "R4 release");
    drain();
  endtask

  always @(posedge clk) begin
    #2;
    if (q.size() != 0) begin
      item_t it;
      it = q.pop_front();
      tests++;
      if (running !== it.run || sample !== it.smp) begin
        fails++;
        $display("FAIL %s: running=%0b sample=%0d expected running=%0b sample=%0d",
                 it.tag, running, sample, it.run, it.smp);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: running=%0b sample=%0d expected run to complete", running, sample);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    tests++;
    if (running !== 1'b0 || sample !== 14'sd0) begin
      fails++;
      $display("FAIL R1 reset: running=%0b sample=%0d expected 0 0", running, sample);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int j = 0; j < 5; j++) push(1'b0, 0, "R1 idle");
    drain();

    run_case(2'b00, 1, 0, 65535, 14, 16400, "R5 rising ramp");
    run_case(2'b01, 0, 0, 1000, 40, 300, "R6 falling ramp, R8 hold zero");
    run_case(2'b10, 1, 0, 65535, 3, 33000, "R7 triangle, R3 short delay");
    run_case(2'b00, 3, 2, 50, 14, 500, "R8 step time, R9 timebase, R10 period");
    run_case(2'b11, 2, 0, 0, 0, 20, "R10 period zero, R7 triangle select");

    @(negedge clk);
    wave_sel = 2'b00; start_delay = 16'd30;
    repeat (3) @(negedge clk);
    trig_n = 1'b0;
    for (int j = 0; j < 5; j++) push(1'b0, 0, "R4 delay");
    drain();
    @(negedge clk);
    trig_n = 1'b1;
    for (int j = 0; j < 40; j++) push(1'b0, 0, "R4 abort during delay");
    drain();

    finish_run();
  end
endmodule